// File: doc/BRIEF.md
# Saturating Integer Arithmetic Unit

This block performs one 32-bit saturating integer operation per cycle. An opcode picks among signed add and subtract with clamping, an add that wraps but still reports signed overflow, a signed doubling clamp, unsigned add and subtract with clamping, and clamping of a value to a programmable bit width. The width clamps come in a signed and an unsigned form. Each also has a dual-lane form that treats the operand as two independent signed 16-bit halves.

The result is purely combinational and is valid in the same cycle the inputs are applied. Every operation that clamps, or that overflows in the wrapping add, raises a saturation event. When the operation is marked valid, the event is captured into a sticky flag on the next rising clock edge. The flag stays set until a clear strobe or a reset. A datapath drives it with decoded operations and reads the flag whenever it needs to know whether any result since the last clear was clamped.

Top module: `sat_alu`

## Requirements
- R1: Opcode 0 (signed add) returns A+B. When A and B have the same sign and the sum's sign differs from A's, it returns 0x7FFFFFFF if A is non-negative and 0x80000000 if A is negative, and raises a saturation event.
- R2: Opcode 1 (signed subtract) returns A-B. When A and B differ in sign and the difference's sign differs from A's, it clamps to 0x7FFFFFFF or 0x80000000 following A's sign, and raises an event.
- R3: Opcode 2 (flagging add) always returns the wrapped 32-bit sum A+B and raises an event exactly when the signed addition overflows.
- R4: Opcode 3 (doubling clamp) returns 2*A. If signed A is at or above 0x40000000 it returns 0x7FFFFFFF. If signed A is at or below 0xC0000000 it returns 0x80000000. Both clamp cases raise an event, including A = 0xC0000000.
- R5: Opcode 4 (unsigned add) returns 0xFFFFFFFF on a carry out of bit 31, and opcode 5 (unsigned subtract) returns 0 when B > A. Each raises an event when it clamps.
- R6: Opcode 6 (signed width clamp) treats A as signed and limits it to the range -2^w .. 2^w-1, where w = width_sel (0..31). It raises an event when it clamps.
- R7: Opcode 7 (unsigned width clamp) treats A as signed and limits it to 0 .. 2^w-1, where w = width_sel. Negative inputs give 0. It raises an event when it clamps.
- R8: Opcodes 8 (signed) and 9 (unsigned) apply the clamps of R6 and R7 separately to the sign-extended low half A[15:0] and high half A[31:16], using w = width_sel[3:0]. They pack the low lane result into bits 15:0 and the high lane result into bits 31:16. A clamp in either lane raises an event.
- R9: On a rising clock edge with op_valid high and a saturation event, sat_flag becomes 1. An edge with op_valid low, or with no event, leaves sat_flag unchanged.
- R10: On a rising edge with flag_clr high, sat_flag becomes 0, unless a valid operation with an event occurs in the same cycle. In that case sat_flag is 1.
- R11: While rst_n is low, sat_flag is 0.
- R12: Opcodes 10 to 15 return 0 and never raise an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Marks the current operation as executed, allowing its event to set the flag |
| op_code | input | 4 | Operation select |
| opnd_a | input | 32 | First operand, or the value to clamp |
| opnd_b | input | 32 | Second operand for add and subtract |
| width_sel | input | 5 | Clamp width for opcodes 6 to 9 |
| flag_clr | input | 1 | Clears the sticky flag on the next edge |
| result | output | 32 | Combinational result |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
Operands are drawn mostly from the regions around the signed and unsigned limits: 0, ±1, 0x3FFFFFFF/0x40000000, 0xBFFFFFFF/0xC0000000/0xC0000001, and the extreme values. This separates the correct sign test from an off-by-one boundary, and tells a signed overflow apart from an unsigned carry. Width clamps are tried at w = 0, 15 and 31 and at random widths, so a lane mix-up or a mask that is wrong by one bit shows up in the packed result. Flag sequences cover an invalid clamping operation, clear alone, and clear together with an event, which tell the update priority apart.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;

  typedef enum logic [3:0] {
    OP_SADD  = 4'd0,
    OP_SSUB  = 4'd1,
    OP_ADDF  = 4'd2,
    OP_DBL   = 4'd3,
    OP_UADD  = 4'd4,
    OP_USUB  = 4'd5,
    OP_SSAT  = 4'd6,
    OP_USAT  = 4'd7,
    OP_SSAT2 = 4'd8,
    OP_USAT2 = 4'd9
  } sat_op_e;

endpackage

// File: rtl/sat_addsub.sv
module sat_addsub #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] sadd_res,
  output logic [DW-1:0] ssub_res,
  output logic [DW-1:0] wrap_sum,
  output logic [DW-1:0] uadd_res,
  output logic [DW-1:0] usub_res,
  output logic          sadd_ovf,
  output logic          ssub_ovf,
  output logic          u_carry,
  output logic          u_borrow
);
  localparam logic [DW-1:0] S_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] S_MIN = {1'b1, {(DW-1){1'b0}}};

  function automatic logic [DW-1:0] rail_for(input logic neg);
    return neg ? S_MIN : S_MAX;
  endfunction

  logic [DW:0]   usum;
  logic [DW:0]   udiff;
  logic [DW-1:0] wrap_diff;

  assign usum      = {1'b0, a} + {1'b0, b};
  assign udiff     = {1'b0, a} - {1'b0, b};
  assign wrap_sum  = usum[DW-1:0];
  assign wrap_diff = udiff[DW-1:0];
  assign u_carry   = usum[DW];
  assign u_borrow  = udiff[DW];

  assign sadd_ovf = (wrap_sum[DW-1] ^ a[DW-1]) & ~(a[DW-1] ^ b[DW-1]);
  assign ssub_ovf = (wrap_diff[DW-1] ^ a[DW-1]) & (a[DW-1] ^ b[DW-1]);

  assign sadd_res = sadd_ovf ? rail_for(a[DW-1]) : wrap_sum;
  assign ssub_res = ssub_ovf ? rail_for(a[DW-1]) : wrap_diff;
  assign uadd_res = u_carry  ? {DW{1'b1}} : wrap_sum;
  assign usub_res = u_borrow ? {DW{1'b0}} : wrap_diff;

endmodule

// File: rtl/sat_double.sv
module sat_double #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  output logic [DW-1:0] res,
  output logic          clip
);
  localparam logic [DW-1:0] QTR_POS = {2'b01, {(DW-2){1'b0}}};
  localparam logic [DW-1:0] QTR_NEG = {2'b11, {(DW-2){1'b0}}};
  localparam logic [DW-1:0] S_MAX   = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] S_MIN   = {1'b1, {(DW-1){1'b0}}};

  logic clip_hi;
  logic clip_lo;

  // Same-sign unsigned compares are valid two's-complement compares.
  assign clip_hi = !a[DW-1] && (a >= QTR_POS);
  assign clip_lo =  a[DW-1] && (a <= QTR_NEG);
  assign clip    = clip_hi | clip_lo;

  always_comb begin
    if (clip_hi)      res = S_MAX;
    else if (clip_lo) res = S_MIN;
    else              res = {a[DW-2:0], 1'b0};
  end

endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
  parameter int IW = 32,
  parameter int WW = 5
) (
  input  logic [IW-1:0] val,
  input  logic [WW-1:0] wid,
  input  logic          uns,
  output logic [IW-1:0] res,
  output logic          clip
);
  function automatic logic [IW-1:0] lim_mask(input logic [WW-1:0] n);
    return (IW'(1) << n) - IW'(1);
  endfunction

  logic [IW-1:0]        mask;
  logic signed [IW-1:0] upper;
  logic                 above_pos;
  logic                 below_neg;

  assign mask      = lim_mask(wid);
  assign upper     = $signed(val) >>> wid;
  assign above_pos = !upper[IW-1] && (upper != '0);
  assign below_neg =  upper[IW-1] && (upper != '1);

  always_comb begin
    res  = val;
    clip = 1'b0;
    if (uns) begin
      if (val[IW-1]) begin
        res  = '0;
        clip = 1'b1;
      end else if (val > mask) begin
        res  = mask;
        clip = 1'b1;
      end
    end else begin
      if (above_pos) begin
        res  = mask;
        clip = 1'b1;
      end else if (below_neg) begin
        res  = ~mask;
        clip = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sat_flag_reg.sv
module sat_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic op_valid,
  input  logic sat_event,
  input  logic clr,
  output logic flag
);
  logic set_now;
  assign set_now = op_valid & sat_event;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_now) flag <= 1'b1;
    else if (clr)     flag <= 1'b0;
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_now |=> flag); // R9
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_now && !clr) |=> $stable(flag)); // R9
  AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_now) |=> !flag); // R10

endmodule

// File: rtl/sat_alu.sv
module sat_alu
  import sat_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        op_valid,
  input  logic [3:0]                  op_code,
  input  logic [DATA_W-1:0]           opnd_a,
  input  logic [DATA_W-1:0]           opnd_b,
  input  logic [$clog2(DATA_W)-1:0]   width_sel,
  input  logic                        flag_clr,
  output logic [DATA_W-1:0]           result,
  output logic                        sat_flag
);
  localparam int HALF_W = DATA_W / 2;
  localparam int WID_W  = $clog2(DATA_W);
  localparam int HWID_W = $clog2(HALF_W);
  localparam int LANES  = 2;
  localparam logic [DATA_W-1:0] S_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] S_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  sat_op_e op_e;
  assign op_e = sat_op_e'(op_code);

  // add / subtract unit
  logic [DATA_W-1:0] sadd_res, ssub_res, wrap_sum, uadd_res, usub_res;
  logic              sadd_ovf, ssub_ovf, u_carry, u_borrow;

  sat_addsub #(.DW(DATA_W)) u_addsub (
    .a(opnd_a), .b(opnd_b),
    .sadd_res(sadd_res), .ssub_res(ssub_res), .wrap_sum(wrap_sum),
    .uadd_res(uadd_res), .usub_res(usub_res),
    .sadd_ovf(sadd_ovf), .ssub_ovf(ssub_ovf),
    .u_carry(u_carry), .u_borrow(u_borrow)
  );

  // doubling clamp
  logic [DATA_W-1:0] dbl_res;
  logic              dbl_clip;

  sat_double #(.DW(DATA_W)) u_double (
    .a(opnd_a), .res(dbl_res), .clip(dbl_clip)
  );

  // full-width clamp
  logic [DATA_W-1:0] full_res;
  logic              full_clip;

  sat_clamp #(.IW(DATA_W), .WW(WID_W)) u_full (
    .val(opnd_a), .wid(width_sel), .uns(op_e == OP_USAT),
    .res(full_res), .clip(full_clip)
  );

  // dual-lane clamps
  logic [LANES-1:0][HALF_W-1:0] lane_res;
  logic [LANES-1:0]             lane_clip;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      sat_clamp #(.IW(HALF_W), .WW(HWID_W)) u_lane (
        .val (opnd_a[l*HALF_W +: HALF_W]),
        .wid (width_sel[HWID_W-1:0]),
        .uns (op_e == OP_USAT2),
        .res (lane_res[l]),
        .clip(lane_clip[l])
      );
    end
  endgenerate

  // result select and saturation event
  logic sat_event;

  always_comb begin
    result    = '0;
    sat_event = 1'b0;
    case (op_e)
      OP_SADD:  begin result = sadd_res; sat_event = sadd_ovf;  end
      OP_SSUB:  begin result = ssub_res; sat_event = ssub_ovf;  end
      OP_ADDF:  begin result = wrap_sum; sat_event = sadd_ovf;  end
      OP_DBL:   begin result = dbl_res;  sat_event = dbl_clip;  end
      OP_UADD:  begin result = uadd_res; sat_event = u_carry;   end
      OP_USUB:  begin result = usub_res; sat_event = u_borrow;  end
      OP_SSAT,
      OP_USAT:  begin result = full_res; sat_event = full_clip; end
      OP_SSAT2,
      OP_USAT2: begin result = lane_res; sat_event = |lane_clip; end
      default:  begin result = '0;       sat_event = 1'b0;      end
    endcase
  end

  sat_flag_reg u_flag (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid),
    .sat_event(sat_event), .clr(flag_clr), .flag(sat_flag)
  );

  AST_SADD_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == OP_SADD && sadd_ovf) |-> result == (opnd_a[DATA_W-1] ? S_MIN : S_MAX)); // R1
  AST_SSUB_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == OP_SSUB && ssub_ovf) |-> result == (opnd_a[DATA_W-1] ? S_MIN : S_MAX)); // R2
  AST_ADDF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == OP_ADDF) |-> result == opnd_a + opnd_b); // R3
  AST_DBL_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == OP_DBL) |-> result[DATA_W-1] == opnd_a[DATA_W-1]); // R4
  AST_UADD_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == OP_UADD) |-> result >= opnd_a); // R5
  AST_USAT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == OP_USAT && opnd_a[DATA_W-1]) |-> (result == '0 && sat_event)); // R7
  AST_UNUSED_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code > 4'd9) |-> (result == '0 && !sat_event)); // R12

endmodule

// File: tb/test_sat_alu.sv
`timescale 1ns/1ps
module test_sat_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = 4'd0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [4:0]  width_sel = '0;
  logic        flag_clr = 1'b0;
  logic [31:0] result;
  logic        sat_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit flag_m = 1'b0;

  always #10 clk = ~clk;

  sat_alu i_sat_alu (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .width_sel(width_sel),
    .flag_clr(flag_clr), .result(result), .sat_flag(sat_flag)
  );

  localparam longint MAXL = 64'sd2147483647;
  localparam longint MINL = -64'sd2147483648;

  function automatic longint clip(input longint v, input longint lo, input longint hi,
                                  inout bit ev);
    if (v > hi) begin ev = 1'b1; return hi; end
    if (v < lo) begin ev = 1'b1; return lo; end
    return v;
  endfunction

  function automatic void ref_op(input logic [3:0] op, input logic [31:0] a, b,
                                 input logic [4:0] w, output logic [31:0] r,
                                 output bit ev);
    longint sa, sb, ua, ub, t, lo, hi, x0, x1;
    int n;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ua = longint'({32'h0, a});
    ub = longint'({32'h0, b});
    ev = 1'b0;
    r  = '0;
    case (op)
      4'd0: begin t = clip(sa + sb, MINL, MAXL, ev); r = t[31:0]; end
      4'd1: begin t = clip(sa - sb, MINL, MAXL, ev); r = t[31:0]; end
      4'd2: begin r = a + b; ev = (sa + sb > MAXL) || (sa + sb < MINL); end
      4'd3: begin
        t  = clip(2 * sa, MINL, MAXL, ev);
        r  = t[31:0];
        ev = (sa >= 64'sd1073741824) || (sa <= -64'sd1073741824);
      end
      4'd4: begin
        if (ua + ub > 64'hFFFF_FFFF) begin r = 32'hFFFF_FFFF; ev = 1'b1; end
        else r = a + b;
      end
      4'd5: begin
        if (ub > ua) begin r = 32'h0; ev = 1'b1; end
        else r = a - b;
      end
      4'd6: begin
        lo = -(64'sd1 <<< w); hi = (64'sd1 <<< w) - 1;
        t = clip(sa, lo, hi, ev); r = t[31:0];
      end
      4'd7: begin
        hi = (64'sd1 <<< w) - 1;
        t = clip(sa, 0, hi, ev); r = t[31:0];
      end
      4'd8, 4'd9: begin
        n  = int'(w[3:0]);
        lo = (op == 4'd8) ? -(64'sd1 <<< n) : 64'sd0;
        hi = (64'sd1 <<< n) - 1;
        x0 = clip(longint'($signed(a[15:0])),  lo, hi, ev);
        x1 = clip(longint'($signed(a[31:16])), lo, hi, ev);
        r  = {x1[15:0], x0[15:0]};
      end
      default: begin r = '0; ev = 1'b0; end
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] op, input logic [31:0] a, b,
                        input logic [4:0] w, input bit vld, input bit clr,
                        input string req);
    logic [31:0] r_exp;
    bit ev;
    @(negedge clk);
    op_code = op; opnd_a = a; opnd_b = b; width_sel = w;
    op_valid = vld; flag_clr = clr;
    #5;
    ref_op(op, a, b, w, r_exp, ev);
    check(req, result, r_exp);
    @(posedge clk);
    #1;
    flag_m = (clr ? 1'b0 : flag_m) | (vld & ev);
    check("R9/R10 flag", {31'h0, sat_flag}, {31'h0, flag_m});
    op_valid = 1'b0; flag_clr = 1'b0;
  endtask

  function automatic logic [31:0] pick_val();
    logic [31:0] corner [12] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
      32'h8000_0000, 32'h3FFF_FFFF, 32'h4000_0000, 32'hBFFF_FFFF,
      32'hC000_0000, 32'hC000_0001, 32'h0000_7FFF, 32'hFFFF_8000};
    if ($urandom_range(0, 1) == 0) return corner[$urandom_range(0, 11)];
    return $urandom();
  endfunction

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset flag", {31'h0, sat_flag}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 signed add clamps both ways and passes normal sums
    run_op(4'd0, 32'h7FFF_FFFF, 32'h1, 5'd0, 1'b1, 1'b0, "R1 pos clamp");
    run_op(4'd1, 32'h0, 32'h0, 5'd0, 1'b1, 1'b1, "R2 zero, clear R10");
    run_op(4'd0, 32'h8000_0000, 32'hFFFF_FFFF, 5'd0, 1'b1, 1'b0, "R1 neg clamp");
    run_op(4'd0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0, 1'b1, 1'b1, "R1 no ovf, clear R10");
    // R2 signed subtract
    run_op(4'd1, 32'h8000_0000, 32'h1, 5'd0, 1'b1, 1'b1, "R2 neg clamp, set beats clear R10");
    run_op(4'd1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0, 1'b0, 1'b1, "R2 pos clamp, invalid R9");
    // R3 flagging add wraps
    run_op(4'd2, 32'h7FFF_FFFF, 32'h1, 5'd0, 1'b1, 1'b0, "R3 wrap with flag");
    // R4 doubling boundaries
    run_op(4'd3, 32'h4000_0000, 32'h0, 5'd0, 1'b1, 1'b1, "R4 at pos quarter");
    run_op(4'd3, 32'h3FFF_FFFF, 32'h0, 5'd0, 1'b1, 1'b1, "R4 below pos quarter");
    run_op(4'd3, 32'hC000_0000, 32'h0, 5'd0, 1'b1, 1'b0, "R4 at neg quarter flags");
    run_op(4'd3, 32'hC000_0001, 32'h0, 5'd0, 1'b1, 1'b1, "R4 above neg quarter");
    // R5 unsigned add/sub
    run_op(4'd4, 32'hFFFF_FFFF, 32'h1, 5'd0, 1'b1, 1'b1, "R5 carry clamp");
    run_op(4'd5, 32'h1, 32'h2, 5'd0, 1'b1, 1'b1, "R5 borrow clamp");
    run_op(4'd5, 32'h5, 32'h5, 5'd0, 1'b1, 1'b1, "R5 equal no clamp");
    // R6 / R7 width clamps
    run_op(4'd6, 32'h0000_0080, 32'h0, 5'd7, 1'b1, 1'b1, "R6 w7 pos clamp");
    run_op(4'd6, 32'hFFFF_FF80, 32'h0, 5'd7, 1'b1, 1'b1, "R6 w7 neg edge");
    run_op(4'd6, 32'h8000_0000, 32'h0, 5'd31, 1'b1, 1'b1, "R6 w31 never clamps");
    run_op(4'd7, 32'h0000_0001, 32'h0, 5'd0, 1'b1, 1'b1, "R7 w0 clamps to 0");
    run_op(4'd7, 32'hFFFF_FFFF, 32'h0, 5'd8, 1'b1, 1'b1, "R7 negative to 0");
    run_op(4'd7, 32'h0000_00FF, 32'h0, 5'd8, 1'b1, 1'b1, "R7 at max");
    // R8 dual lanes
    run_op(4'd8, 32'h8000_7FFF, 32'h0, 5'd3, 1'b1, 1'b1, "R8 signed lanes");
    run_op(4'd9, 32'h0005_FFFF, 32'h0, 5'd3, 1'b1, 1'b1, "R8 unsigned lanes");
    run_op(4'd8, 32'h1234_8000, 32'h0, 5'd15, 1'b1, 1'b1, "R8 w15 passthrough");
    // R12 unused opcodes
    run_op(4'd10, 32'hFFFF_FFFF, 32'h1, 5'd0, 1'b1, 1'b0, "R12 op10 zero");
    run_op(4'd15, 32'h7FFF_FFFF, 32'h1, 5'd0, 1'b1, 1'b0, "R12 op15 zero");

    // random mix
    for (int k = 0; k < 600; k++) begin
      run_op(4'($urandom_range(0, 11)), pick_val(), pick_val(),
             5'($urandom_range(0, 31)), 1'($urandom_range(0, 3) != 0),
             1'($urandom_range(0, 7) == 0), "R1-R8 random");
    end

    // reset mid-run clears flag
    run_op(4'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 5'd0, 1'b1, 1'b0, "R1 set before reset");
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    check("R11 async reset", {31'h0, sat_flag}, 32'h0);
    flag_m = 1'b0;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule